// File: doc/BRIEF.md
# DS2 Frame Multiplexer

This block assembles a serial DS2 bit stream out of four DS1 tributary bit streams. Each enabled cycle emits exactly one DS2 bit. Payload bits are pulled one at a time from the tributaries in strict rotation. A single overhead bit is inserted ahead of every 48-bit payload packet, so one frame carries 24 overhead bits and 1152 payload bits, 1176 bits in all. A tributary is told that its bit was taken by a read strobe. That strobe is raised combinationally in the cycle the bit is consumed, and the tributary's data input is sampled at the same clock edge.

The frame is made of four subframes, each of six packets. The overhead bit in front of each packet, in order, is: a multiframe-marker bit, a stuffing-control bit, an alignment zero, two more stuffing-control bits, and an alignment one. The marker bit is 0 in the first subframe and 1 in the second and third. In the fourth subframe it is a value taken from a configuration input. Stuffing-control values are not computed here. One input bit per subframe is captured at that subframe's marker bit, and the three control bits of that subframe repeat it.

The serial bit, its valid strobe, the frame-start marker and the subframe index are all registered. Each appears one clock after the enabled cycle that produced it.

Top module: `ds2_frame_mux`

## Requirements
- R1: The frame is 1176 emitted bits long. After a reset, `frameStart` is high together with `serValid` on emitted bits 0, 1176, 2352 and so on, and never on any other emitted bit.
- R2: Emitted bit n (counted from 0 after reset, modulo 1176) is an overhead bit exactly when n mod 49 = 0. Bit n belongs to subframe n div 294 (0 to 3), and the overhead index within that subframe is (n mod 294) div 49 (0 to 5).
- R3: Overhead index 2 carries 0 and overhead index 5 carries 1. Overhead indices 1, 3 and 4 carry the subframe's captured stuffing-control value.
- R4: Overhead index 0 carries 0 in subframe 0 and 1 in subframes 1 and 2. In subframe 3 it carries `xBit` as sampled in the cycle that bit is emitted.
- R5: Payload bit n with p = (n mod 49) − 1 comes from tributary p mod 4. Its value is the bit on `tribData[p mod 4]` in the enabled cycle that consumes it.
- R6: `tribRd[k]` is high in exactly those cycles where `outEn` is high and the current bit is a payload bit from tributary k. It is low on overhead bits and whenever `outEn` is low, and at most one bit of `tribRd` is ever high.
- R7: At the overhead-index-0 bit of subframe s, `cBit[s]` is captured. The three stuffing-control bits of subframe s carry that captured value, and changes on `cBit` at other times have no effect on them.
- R8: On the overhead-index-0 bit of subframe s, `subframeIdx` becomes s, registered together with that bit. It holds its value at all other times.
- R9: Each enabled cycle produces one output bit, with `serValid` high on the next cycle. A cycle with `outEn` low advances nothing, and `serValid` is low on the next cycle.
- R10: A synchronous `rst` clears `serOut`, `serValid`, `frameStart`, `subframeIdx` and the captured control values. The next emitted bit is then bit 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| outEn | input | 1 | Emit one DS2 bit this cycle |
| tribData | input | 4 | Current data bit of each tributary |
| tribRd | output | 4 | Per-tributary consume strobe (combinational) |
| xBit | input | 1 | Value of the fourth subframe's marker bit |
| cBit | input | 4 | Stuffing-control value per subframe |
| serOut | output | 1 | Serial DS2 bit |
| serValid | output | 1 | `serOut` holds a new bit |
| frameStart | output | 1 | `serOut` is the first bit of a frame |
| subframeIdx | output | 2 | Index of the subframe being emitted |

## Verification
The bench first runs more than a full frame with `outEn` held high. This shows that a continuous stream lands every overhead bit in exactly its position. It then gates `outEn` randomly, which separates true bit counting from cycle counting. Tributary data, `xBit` and `cBit` change at random every cycle, so the output only matches if each value is sampled at its own moment: tributary bits when consumed, the marker value when emitted, and the control values at the subframe start. A reset issued in the middle of a frame checks that alignment restarts at bit 0.

// File: rtl/ds2_mux_pkg.sv
package ds2_mux_pkg;

  // DS2 layout constants
  parameter int DS2_PKT_BITS  = 48;
  parameter int DS2_NUM_TRIB  = 4;
  parameter int DS2_BLK_PER_SF = 6;
  parameter int DS2_NUM_SF    = 4;

  localparam int TRIB_W = $clog2(DS2_NUM_TRIB);
  localparam int SF_W   = $clog2(DS2_NUM_SF);

  typedef enum logic [2:0] {
    OH_NONE = 3'd0,
    OH_MARK = 3'd1,
    OH_CBIT = 3'd2,
    OH_FZRO = 3'd3,
    OH_FONE = 3'd4
  } ohKind_t;

  // control -> datapath strobes for the current bit position
  typedef struct packed {
    logic              payload;
    ohKind_t           ohKind;
    logic [TRIB_W-1:0] tribSel;
    logic [SF_W-1:0]   sfIdx;
    logic              frameMark;
  } ds2Strobe_t;

endpackage

// File: rtl/ds2_mux_ctrl.sv
module ds2_mux_ctrl
  import ds2_mux_pkg::*;
#(
  parameter int PktBits   = DS2_PKT_BITS,
  parameter int NumTrib   = DS2_NUM_TRIB,
  parameter int BlksPerSf = DS2_BLK_PER_SF,
  parameter int NumSf     = DS2_NUM_SF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       outEn,
  output ds2Strobe_t strobe
);

  localparam int BlkLen   = PktBits + 1;
  localparam int SfLen    = BlkLen * BlksPerSf;
  localparam int FrameLen = SfLen * NumSf;
  localparam int OffW     = $clog2(BlkLen);
  localparam int BlkW     = $clog2(BlksPerSf);
  localparam int PosW     = $clog2(FrameLen);

  localparam logic [OffW-1:0]   OffLast  = OffW'(BlkLen - 1);
  localparam logic [BlkW-1:0]   BlkLast  = BlkW'(BlksPerSf - 1);
  localparam logic [SF_W-1:0]   SfLast   = SF_W'(NumSf - 1);
  localparam logic [TRIB_W-1:0] TribLast = TRIB_W'(NumTrib - 1);
  localparam logic [PosW-1:0]   PosLast  = PosW'(FrameLen - 1);

  logic [OffW-1:0]   offCnt;
  logic [BlkW-1:0]   blkCnt;
  logic [SF_W-1:0]   sfCnt;
  logic [TRIB_W-1:0] tribCnt;
  logic [PosW-1:0]   bitPos;

  // position counters: advance only on enabled cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      offCnt  <= '0;
      blkCnt  <= '0;
      sfCnt   <= '0;
      tribCnt <= '0;
      bitPos  <= '0;
    end else if (outEn) begin
      bitPos <= (bitPos == PosLast) ? '0 : bitPos + 1'b1;
      if (offCnt == OffLast) begin
        offCnt <= '0;
        if (blkCnt == BlkLast) begin
          blkCnt <= '0;
          sfCnt  <= (sfCnt == SfLast) ? '0 : sfCnt + 1'b1;
        end else begin
          blkCnt <= blkCnt + 1'b1;
        end
      end else begin
        offCnt <= offCnt + 1'b1;
      end
      if (offCnt == '0) tribCnt <= '0;
      else tribCnt <= (tribCnt == TribLast) ? '0 : tribCnt + 1'b1;
    end
  end

  // decode the current position into datapath strobes
  always_comb begin
    strobe           = '0;
    strobe.sfIdx     = sfCnt;
    strobe.tribSel   = tribCnt;
    strobe.payload   = (offCnt != '0);
    strobe.frameMark = (bitPos == '0);
    if (offCnt == '0) begin
      if (blkCnt == '0)           strobe.ohKind = OH_MARK;
      else if (blkCnt == BlkW'(2)) strobe.ohKind = OH_FZRO;
      else if (blkCnt == BlkLast)  strobe.ohKind = OH_FONE;
      else                         strobe.ohKind = OH_CBIT;
    end else begin
      strobe.ohKind = OH_NONE;
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (outEn && bitPos == PosLast) |=> (bitPos == '0 && offCnt == '0 && blkCnt == '0 && sfCnt == '0));

  assert_align_R2: assert property (@(posedge clk) disable iff (rst)
    (bitPos == '0) |-> (offCnt == '0 && blkCnt == '0 && sfCnt == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !outEn |=> ($stable(bitPos) && $stable(offCnt) && $stable(tribCnt)));

endmodule

// File: rtl/ds2_mux_dpath.sv
module ds2_mux_dpath
  import ds2_mux_pkg::*;
#(
  parameter int NumTrib = DS2_NUM_TRIB,
  parameter int NumSf   = DS2_NUM_SF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               outEn,
  input  ds2Strobe_t         strobe,
  input  logic [NumTrib-1:0] tribData,
  input  logic               xBit,
  input  logic [NumSf-1:0]   cBit,
  output logic [NumTrib-1:0] tribRd,
  output logic               serOut,
  output logic               serValid,
  output logic               frameStart,
  output logic [SF_W-1:0]    subframeIdx
);

  localparam logic [SF_W-1:0] SfLast = SF_W'(NumSf - 1);

  logic cLatch;
  logic markVal;
  logic nextBit;

  for (genvar k = 0; k < NumTrib; k++) begin : gRd
    assign tribRd[k] = outEn && strobe.payload && (strobe.tribSel == TRIB_W'(k));
  end

  always_comb begin
    if (strobe.sfIdx == '0)         markVal = 1'b0;
    else if (strobe.sfIdx == SfLast) markVal = xBit;
    else                             markVal = 1'b1;
  end

  always_comb begin
    case (strobe.ohKind)
      OH_MARK: nextBit = markVal;
      OH_CBIT: nextBit = cLatch;
      OH_FZRO: nextBit = 1'b0;
      OH_FONE: nextBit = 1'b1;
      default: nextBit = tribData[strobe.tribSel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      serOut      <= 1'b0;
      serValid    <= 1'b0;
      frameStart  <= 1'b0;
      subframeIdx <= '0;
      cLatch      <= 1'b0;
    end else begin
      serValid   <= outEn;
      frameStart <= outEn && strobe.frameMark;
      if (outEn) begin
        serOut <= nextBit;
        if (strobe.ohKind == OH_MARK) begin
          cLatch      <= cBit[strobe.sfIdx];
          subframeIdx <= strobe.sfIdx;
        end
      end
    end
  end

  assert_rd_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tribRd));

  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !outEn |-> (tribRd == '0));

  assert_valid_R9: assert property (@(posedge clk) disable iff (rst)
    outEn |=> serValid);

  assert_novalid_R9: assert property (@(posedge clk) disable iff (rst)
    !outEn |=> !serValid);

  assert_m0_zero_R4: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (serValid && !serOut && subframeIdx == '0));

endmodule

// File: rtl/ds2_frame_mux.sv
module ds2_frame_mux
  import ds2_mux_pkg::*;
#(
  parameter int PktBits   = DS2_PKT_BITS,
  parameter int NumTrib   = DS2_NUM_TRIB,
  parameter int BlksPerSf = DS2_BLK_PER_SF,
  parameter int NumSf     = DS2_NUM_SF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               outEn,
  input  logic [NumTrib-1:0] tribData,
  output logic [NumTrib-1:0] tribRd,
  input  logic               xBit,
  input  logic [NumSf-1:0]   cBit,
  output logic               serOut,
  output logic               serValid,
  output logic               frameStart,
  output logic [SF_W-1:0]    subframeIdx
);

  ds2Strobe_t strobe;

  ds2_mux_ctrl #(
    .PktBits(PktBits), .NumTrib(NumTrib), .BlksPerSf(BlksPerSf), .NumSf(NumSf)
  ) uCtrl (
    .clk(clk), .rst(rst), .outEn(outEn), .strobe(strobe)
  );

  ds2_mux_dpath #(
    .NumTrib(NumTrib), .NumSf(NumSf)
  ) uDpath (
    .clk(clk), .rst(rst), .outEn(outEn), .strobe(strobe),
    .tribData(tribData), .xBit(xBit), .cBit(cBit),
    .tribRd(tribRd), .serOut(serOut), .serValid(serValid),
    .frameStart(frameStart), .subframeIdx(subframeIdx)
  );

endmodule

// File: tb/ds2_frame_mux_test.sv
`timescale 1ns/1ps
module ds2_frame_mux_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       outEn;
  logic [3:0] tribData;
  logic [3:0] tribRd;
  logic       xBit;
  logic [3:0] cBit;
  logic       serOut, serValid, frameStart;
  logic [1:0] subframeIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  ds2_frame_mux uut (
    .clk(clk), .rst(rst), .outEn(outEn), .tribData(tribData), .tribRd(tribRd),
    .xBit(xBit), .cBit(cBit), .serOut(serOut), .serValid(serValid),
    .frameStart(frameStart), .subframeIdx(subframeIdx)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected serial bit for frame position pos (R2..R5, R7)
  function automatic logic expBit(int pos, logic x, logic cl, logic [3:0] d);
    int sf, r, blk, off;
    sf  = pos / 294;
    r   = pos % 294;
    blk = r / 49;
    off = r % 49;
    if (off != 0) return d[(off - 1) % 4];
    case (blk)
      0: return (sf == 0) ? 1'b0 : (sf == 3) ? x : 1'b1;
      2: return 1'b0;
      5: return 1'b1;
      default: return cl;
    endcase
  endfunction

  function automatic logic [3:0] expRd(int pos, logic en);
    int off;
    off = (pos % 294) % 49;
    if (!en || off == 0) return 4'b0000;
    return 4'b0001 << ((off - 1) % 4);
  endfunction

  int   mPos;
  logic mCl;
  logic eValid, eOut, eFs;
  int   eSf;

  task automatic modelReset();
    mPos = 0; mCl = 0; eValid = 0; eOut = 0; eFs = 0; eSf = 0;
  endtask

  initial begin
    void'($urandom(1234));
    rst = 1; outEn = 0; tribData = 0; xBit = 0; cBit = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    chk("R10 serValid", serValid, 0);
    chk("R10 serOut", serOut, 0);
    chk("R10 frameStart", frameStart, 0);
    chk("R10 subframeIdx", subframeIdx, 0);
    for (int cyc = 0; cyc < 7000; cyc++) begin
      logic doRst;
      if (cyc > 0) @(negedge clk);
      // compare registered outputs from previous cycle
      chk("R9 serValid", serValid, eValid);
      if (eValid) chk("R3/R4/R5/R7 serOut", serOut, eOut);
      chk("R1 frameStart", frameStart, eFs);
      chk("R8 subframeIdx", subframeIdx, eSf);
      doRst = (cyc == 4100);
      rst   = doRst;
      outEn = doRst ? 1'b0 : (cyc < 1300) ? 1'b1 : (($urandom % 4) != 0);
      tribData = 4'($urandom);
      xBit  = 1'($urandom);
      cBit  = 4'($urandom);
      #1;
      if (doRst) begin
        modelReset();
        continue;
      end
      chk("R6 tribRd", tribRd, expRd(mPos, outEn));
      if (outEn) begin
        if (mPos % 294 == 0) begin
          mCl = cBit[mPos / 294];
          eSf = mPos / 294;
        end
        eOut   = expBit(mPos, xBit, mCl, tribData);
        eValid = 1;
        eFs    = (mPos == 0);
        mPos   = (mPos + 1) % 1176;
      end else begin
        eValid = 0;
        eFs    = 0;
      end
    end
    @(negedge clk);
    chk("R9 serValid final", serValid, eValid);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule